// File: doc/BRIEF.md
# Processor Clock-Control Power State Machine

This block follows the clock-control power state of a processor core. It has five states: running (Normal), halted after a halt instruction (AutoHALT), clock stopped by request (Stop-Grant), a snoop-service state entered from AutoHALT or Stop-Grant, and Sleep. Its inputs are a halt-instruction strobe, an active-low stop-clock request, an active-low sleep request, a system reset, a vector of wake sources (for example system-management, init, NMI, INTR and bus interrupt messages), a bus-snoop indication, and a strobe that marks the response phase of the stop-grant acknowledge cycle.

Every state is registered. A stop-clock request seen in Normal or AutoHALT raises a one-cycle acknowledge request. The block then waits for the response strobe. From that strobe it counts a programmable number of clocks and then enters Stop-Grant. It records whether the request came from AutoHALT, so that releasing stop-clock later returns the core to that state and not to Normal. A system reset in Stop-Grant sends a core-initialize pulse and the state does not change. In every other state the reset returns the core to Normal. A sequencing guard raises a sticky flag if stop-clock is released too soon after sleep is released.

Top module: `clkctl_pstate`

## Requirements
- R1: After power-on reset (`rst_n` low), `pstate` is 5'b00001 and `core_clk_en` is 1. `sga_req`, `core_init` and `seq_err` are 0. The one-hot state bits are: bit0 Normal, bit1 AutoHALT, bit2 Stop-Grant, bit3 Snoop, bit4 Sleep. Exactly one bit is set at all times.
- R2: When `halt_exec` is sampled high in Normal, the state is AutoHALT from the next cycle, and `core_clk_en` is high only in Normal.
- R3: When any bit of `wake_req` is sampled high in AutoHALT, the state returns to Normal on the next cycle.
- R4: When `stopclk_n` is first sampled low (high on the previous sample) in Normal or AutoHALT, `sga_req` is high for exactly the following cycle.
- R5: When `sga_resp` is sampled high while a request is pending, Stop-Grant is entered exactly GRANT_DELAY clock edges later, provided `stopclk_n` stays low.
- R6: When `stopclk_n` is sampled high in Stop-Grant, the state moves to AutoHALT if Stop-Grant was entered from AutoHALT, and to Normal otherwise.
- R7: When `sys_reset` is sampled high in Stop-Grant, `core_init` pulses for one cycle and the state stays Stop-Grant.
- R8: When `sys_reset` is sampled high in any other state, the state returns to Normal and `core_init` pulses for one cycle.
- R9: When `snoop` is sampled high in Stop-Grant, or in AutoHALT with no wake request, the state moves to Snoop. It returns to its origin on the edge at which `snoop` is first sampled low.
- R10: When `sleep_n` is sampled low in Stop-Grant, the state moves to Sleep. When `sleep_n` is sampled high in Sleep, it returns to Stop-Grant.
- R11: `seq_err` is set if `stopclk_n` is sampled high fewer than SLEEP_GAP edges after the edge at which sleep was released. It is not set at exactly SLEEP_GAP edges. Once set, it stays high until power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| halt_exec | input | 1 | Halt-instruction strobe |
| stopclk_n | input | 1 | Stop-clock request, active low |
| sleep_n | input | 1 | Sleep request, active low |
| sys_reset | input | 1 | System reset request |
| wake_req | input | WAKE_W | Wake sources; any set bit wakes AutoHALT |
| snoop | input | 1 | Bus snoop in progress |
| sga_resp | input | 1 | Response-phase strobe of the acknowledge cycle |
| pstate | output | 5 | One-hot power state |
| core_clk_en | output | 1 | Core clock enable, high in Normal |
| sga_req | output | 1 | One-cycle stop-grant acknowledge request |
| core_init | output | 1 | One-cycle core initialize pulse |
| seq_err | output | 1 | Sticky stop-clock/sleep sequencing violation |

## Verification
The bench builds the block with GRANT_DELAY = 4 and SLEEP_GAP = 3. These short windows let a single run count every edge of the Stop-Grant entry delay and probe the release spacing on both sides of its limit. The spacing is exercised at exactly the limit, which must leave the flag clear, and one edge after sleep release, which must set it. Stop-Grant is entered once from Normal and once from AutoHALT, so both return paths are seen. Resets, snoops and sleep are also applied in Stop-Grant and in AutoHALT.

// File: rtl/cps_pkg.sv
package cps_pkg;
   localparam int PS_COUNT = 5;

   typedef enum logic [2:0] {
      PS_RUN   = 3'd0,
      PS_HALT  = 3'd1,
      PS_GRANT = 3'd2,
      PS_SNOOP = 3'd3,
      PS_SLEEP = 3'd4
   } pstate_e;

   function automatic logic [PS_COUNT-1:0] ps_onehot(input pstate_e s);
      logic [PS_COUNT-1:0] v;
      v = '0;
      v[int'(s)] = 1'b1;
      return v;
   endfunction
endpackage

// File: rtl/cps_countdown.sv
module cps_countdown #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         clear,
   input  logic [W-1:0] load_val,
   output logic         nz
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (clear)       cnt <= '0;
      else if (load)        cnt <= load_val;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign nz = (cnt != '0);

   // R5
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nz && !load && !clear) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/cps_seq_guard.sv
module cps_seq_guard #(
   parameter int SLEEP_GAP = 10,
   parameter int GAP_W     = 4,
   parameter bit CHECK_EN  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_exit,
   input  logic stop_rel_grant,
   input  logic stop_rel_sleep,
   output logic seq_err
);
   generate
      if (CHECK_EN) begin : g_guard
         logic gap_nz;
         logic err_q;

         cps_countdown #(.W(GAP_W)) u_gap (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (sleep_exit),
            .clear    (1'b0),
            .load_val (GAP_W'(SLEEP_GAP - 1)),
            .nz       (gap_nz)
         );

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) err_q <= 1'b0;
            else if ((stop_rel_grant && gap_nz) || stop_rel_sleep) err_q <= 1'b1;
         end

         assign seq_err = err_q;

         // R11
         err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            err_q |=> err_q);
      end else begin : g_noguard
         assign seq_err = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/cps_state_fsm.sv
module cps_state_fsm
   import cps_pkg::*;
#(
   parameter int GRANT_DELAY = 20,
   parameter int DLY_W       = 5,
   parameter int WAKE_W      = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              halt_exec,
   input  logic              stopclk_n,
   input  logic              sleep_n,
   input  logic              sys_reset,
   input  logic [WAKE_W-1:0] wake_req,
   input  logic              snoop,
   input  logic              sga_resp,
   output pstate_e           state,
   output logic              sga_req,
   output logic              core_init,
   output logic              sleep_exit,
   output logic              stop_rel_grant,
   output logic              stop_rel_sleep
);
   pstate_e nxt;
   logic    stop_q, pend, armed, from_halt, ret_grant;
   logic    stop_fall, req_ok, in_run_halt, cancel, resp_take, grant_go, dly_nz;

   assign stop_fall   = !stopclk_n && stop_q;
   assign req_ok      = (state != PS_GRANT) && (state != PS_SLEEP);
   assign in_run_halt = (state == PS_RUN) || (state == PS_HALT);
   assign cancel      = stopclk_n || (sys_reset && (state != PS_GRANT));
   assign resp_take   = pend && sga_resp && !cancel;
   assign grant_go    = armed && !dly_nz && in_run_halt && !cancel;

   cps_countdown #(.W(DLY_W)) u_dly (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (resp_take),
      .clear    (cancel),
      .load_val (DLY_W'(GRANT_DELAY - 1)),
      .nz       (dly_nz)
   );

   always_comb begin
      nxt = state;
      unique case (state)
         PS_RUN: begin
            if (sys_reset)      nxt = PS_RUN;
            else if (grant_go)  nxt = PS_GRANT;
            else if (halt_exec) nxt = PS_HALT;
         end
         PS_HALT: begin
            if (sys_reset)      nxt = PS_RUN;
            else if (grant_go)  nxt = PS_GRANT;
            else if (|wake_req) nxt = PS_RUN;
            else if (snoop)     nxt = PS_SNOOP;
         end
         PS_GRANT: begin
            if (sys_reset)      nxt = PS_GRANT;
            else if (stopclk_n) nxt = from_halt ? PS_HALT : PS_RUN;
            else if (!sleep_n)  nxt = PS_SLEEP;
            else if (snoop)     nxt = PS_SNOOP;
         end
         PS_SNOOP: begin
            if (sys_reset)      nxt = PS_RUN;
            else if (!snoop)    nxt = ret_grant ? PS_GRANT : PS_HALT;
         end
         PS_SLEEP: begin
            if (sys_reset)      nxt = PS_RUN;
            else if (sleep_n)   nxt = PS_GRANT;
         end
         default:               nxt = PS_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= PS_RUN;
         stop_q    <= 1'b1;
         sga_req   <= 1'b0;
         core_init <= 1'b0;
         pend      <= 1'b0;
         armed     <= 1'b0;
         from_halt <= 1'b0;
         ret_grant <= 1'b0;
      end else begin
         state     <= nxt;
         stop_q    <= stopclk_n;
         sga_req   <= stop_fall && req_ok && !sys_reset;
         core_init <= sys_reset;
         if (cancel)                      pend <= 1'b0;
         else if (stop_fall && req_ok)    pend <= 1'b1;
         else if (resp_take)              pend <= 1'b0;
         if (cancel)                      armed <= 1'b0;
         else if (resp_take)              armed <= 1'b1;
         else if (grant_go)               armed <= 1'b0;
         if (grant_go)                    from_halt <= (state == PS_HALT);
         if (nxt == PS_SNOOP && state != PS_SNOOP) ret_grant <= (state == PS_GRANT);
      end
   end

   assign sleep_exit     = (state == PS_SLEEP) && sleep_n && !sys_reset;
   assign stop_rel_grant = (state == PS_GRANT) && stopclk_n && !sys_reset;
   assign stop_rel_sleep = (state == PS_SLEEP) && stopclk_n;

   // R4
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sga_req |=> !sga_req);

   // R7
   grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PS_GRANT && sys_reset) |=> (state == PS_GRANT && core_init));

   // R9
   snoop_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PS_SNOOP && !snoop && !sys_reset) |=> (state == PS_GRANT || state == PS_HALT));

   // R10
   sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state == PS_SLEEP) |-> ($past(state) == PS_GRANT));
endmodule

// File: rtl/clkctl_pstate.sv
module clkctl_pstate
   import cps_pkg::*;
#(
   parameter int GRANT_DELAY  = 20,
   parameter int SLEEP_GAP    = 10,
   parameter int WAKE_W       = 5,
   parameter bit SEQ_CHECK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              halt_exec,
   input  logic              stopclk_n,
   input  logic              sleep_n,
   input  logic              sys_reset,
   input  logic [WAKE_W-1:0] wake_req,
   input  logic              snoop,
   input  logic              sga_resp,
   output logic [4:0]        pstate,
   output logic              core_clk_en,
   output logic              sga_req,
   output logic              core_init,
   output logic              seq_err
);
   localparam int DLY_W = $clog2(GRANT_DELAY + 1);
   localparam int GAP_W = $clog2(SLEEP_GAP + 1);

   generate
      if (GRANT_DELAY < 1) begin : g_bad_delay
         $error("GRANT_DELAY must be at least 1");
      end
      if (SLEEP_GAP < 1) begin : g_bad_gap
         $error("SLEEP_GAP must be at least 1");
      end
      if (WAKE_W < 1) begin : g_bad_wake
         $error("WAKE_W must be at least 1");
      end
   endgenerate

   pstate_e state;
   logic    sleep_exit, stop_rel_grant, stop_rel_sleep;

   cps_state_fsm #(
      .GRANT_DELAY (GRANT_DELAY),
      .DLY_W       (DLY_W),
      .WAKE_W      (WAKE_W)
   ) u_fsm (
      .clk            (clk),
      .rst_n          (rst_n),
      .halt_exec      (halt_exec),
      .stopclk_n      (stopclk_n),
      .sleep_n        (sleep_n),
      .sys_reset      (sys_reset),
      .wake_req       (wake_req),
      .snoop          (snoop),
      .sga_resp       (sga_resp),
      .state          (state),
      .sga_req        (sga_req),
      .core_init      (core_init),
      .sleep_exit     (sleep_exit),
      .stop_rel_grant (stop_rel_grant),
      .stop_rel_sleep (stop_rel_sleep)
   );

   cps_seq_guard #(
      .SLEEP_GAP (SLEEP_GAP),
      .GAP_W     (GAP_W),
      .CHECK_EN  (SEQ_CHECK_EN)
   ) u_guard (
      .clk            (clk),
      .rst_n          (rst_n),
      .sleep_exit     (sleep_exit),
      .stop_rel_grant (stop_rel_grant),
      .stop_rel_sleep (stop_rel_sleep),
      .seq_err        (seq_err)
   );

   assign pstate      = ps_onehot(state);
   assign core_clk_en = (state == PS_RUN);

   // R1
   state_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(pstate) == 1);

   // R2
   clk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_clk_en |-> !pstate[1] && !pstate[2] && !pstate[4]);
endmodule

// File: tb/sim_clkctl_pstate.sv
module sim_clkctl_pstate;
   localparam logic [4:0] N = 5'b00001, H = 5'b00010, G = 5'b00100, S = 5'b01000, L = 5'b10000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic halt_exec = 1'b0, stopclk_n = 1'b1, sleep_n = 1'b1, sys_reset = 1'b0;
   logic snoop = 1'b0, sga_resp = 1'b0;
   logic [4:0] wake_req = '0;
   logic [4:0] pstate;
   logic core_clk_en, sga_req, core_init, seq_err;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct {
      string      tag;
      logic [4:0] st;
      logic       req;
      logic       init;
      logic       err;
   } exp_t;

   exp_t expq[$];
   exp_t e;

   always #5 clk = ~clk;

   clkctl_pstate #(.GRANT_DELAY(4), .SLEEP_GAP(3), .WAKE_W(5)) u0 (
      .clk(clk), .rst_n(rst_n), .halt_exec(halt_exec), .stopclk_n(stopclk_n),
      .sleep_n(sleep_n), .sys_reset(sys_reset), .wake_req(wake_req), .snoop(snoop),
      .sga_resp(sga_resp), .pstate(pstate), .core_clk_en(core_clk_en),
      .sga_req(sga_req), .core_init(core_init), .seq_err(seq_err));

   always @(negedge clk) begin
      while (expq.size() != 0) begin
         e = expq.pop_front();
         checks++;
         if (pstate !== e.st || core_clk_en !== (e.st == N) || sga_req !== e.req ||
             core_init !== e.init || seq_err !== e.err) begin
            fails++;
            $display("FAIL %s: got st=%b en=%b req=%b init=%b err=%b, exp st=%b en=%b req=%b init=%b err=%b",
                     e.tag, pstate, core_clk_en, sga_req, core_init, seq_err,
                     e.st, (e.st == N), e.req, e.init, e.err);
         end
      end
   end

   task automatic tick(input string tag, input logic [4:0] st, input logic req,
                       input logic init, input logic err);
      @(posedge clk);
      #1;
      expq.push_back('{tag, st, req, init, err});
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      tick("R1 reset state", N, 0, 0, 0);

      halt_exec = 1'b1; tick("R2 halt", H, 0, 0, 0);
      halt_exec = 1'b0; tick("R2 stay halted", H, 0, 0, 0);
      wake_req = 5'b00100; tick("R3 wake bit2", N, 0, 0, 0);
      wake_req = '0; halt_exec = 1'b1; tick("R2 halt again", H, 0, 0, 0);
      halt_exec = 1'b0; wake_req = 5'b10000; tick("R3 wake bit4", N, 0, 0, 0);
      wake_req = '0;

      stopclk_n = 1'b0; tick("R4 request pulse", N, 1, 0, 0);
      tick("R4 pulse ends", N, 0, 0, 0);
      sga_resp = 1'b1; tick("R5 resp edge", N, 0, 0, 0);
      sga_resp = 1'b0;
      tick("R5 delay 1", N, 0, 0, 0);
      tick("R5 delay 2", N, 0, 0, 0);
      tick("R5 delay 3", N, 0, 0, 0);
      tick("R5 grant entered", G, 0, 0, 0);
      sys_reset = 1'b1; tick("R7 init in grant", G, 0, 1, 0);
      sys_reset = 1'b0; tick("R7 init ends", G, 0, 0, 0);
      snoop = 1'b1; tick("R9 snoop from grant", S, 0, 0, 0);
      tick("R9 snoop held", S, 0, 0, 0);
      snoop = 1'b0; tick("R9 back to grant", G, 0, 0, 0);
      sleep_n = 1'b0; tick("R10 sleep", L, 0, 0, 0);
      tick("R10 sleep held", L, 0, 0, 0);
      sleep_n = 1'b1; tick("R10 sleep release", G, 0, 0, 0);
      tick("R11 gap 1", G, 0, 0, 0);
      tick("R11 gap 2", G, 0, 0, 0);
      stopclk_n = 1'b1; tick("R6 R11 release at limit to normal", N, 0, 0, 0);

      halt_exec = 1'b1; tick("R2 halt before stop", H, 0, 0, 0);
      halt_exec = 1'b0; stopclk_n = 1'b0; tick("R4 request from halt", H, 1, 0, 0);
      sga_resp = 1'b1; tick("R5 resp from halt", H, 0, 0, 0);
      sga_resp = 1'b0;
      tick("R5 halt delay 1", H, 0, 0, 0);
      tick("R5 halt delay 2", H, 0, 0, 0);
      tick("R5 halt delay 3", H, 0, 0, 0);
      tick("R5 grant from halt", G, 0, 0, 0);
      sleep_n = 1'b0; tick("R10 sleep 2", L, 0, 0, 0);
      sleep_n = 1'b1; tick("R10 release 2", G, 0, 0, 0);
      stopclk_n = 1'b1; tick("R6 R11 early release to halt", H, 0, 0, 1);
      tick("R11 sticky", H, 0, 0, 1);
      snoop = 1'b1; tick("R9 snoop from halt", S, 0, 0, 1);
      snoop = 1'b0; tick("R9 back to halt", H, 0, 0, 1);
      sys_reset = 1'b1; tick("R8 reset from halt", N, 0, 1, 1);
      sys_reset = 1'b0; tick("R8 init ends", N, 0, 0, 1);

      @(negedge clk);
      #1 rst_n = 1'b0;
      @(posedge clk);
      #1 rst_n = 1'b1;
      tick("R1 R11 power-on clears flag", N, 0, 0, 0);

      @(negedge clk);
      #2;
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      #2000000;
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout, exp completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule